// File: doc/BRIEF.md
# Multi-Format Serial Audio Input Receiver

This block takes stereo PCM audio arriving on three serial wires (a bit clock, a word-select line and a data line) and delivers each left/right sample pair to the core clock domain as two parallel 24-bit two's complement words. A 4-bit format field picks one of four framing conventions and one of three word lengths. The serial wires need no fixed frequency relation to the core clock.

A single shift register and bit counter, clocked by the bit clock, serve every framing convention. In each convention the word-select line has its own meaning: a level that names the channel, or a one-bit sync pulse. Data is sent MSB first. Shorter words are placed in the upper bits of the 24-bit output and the low bits are cleared, so every width reads as the same full-scale 24-bit value. When a right word finishes, the pair is frozen in a holding register and a toggle is flipped. The core side synchronizes the toggle through two flops, catches its edge and presents the pair with a one-cycle strobe.

The format field and the reset must be static while the bit clock runs. Reset is sampled synchronously in both clock domains, so the bit clock has to run for a few periods while reset is held.

Top module: `audrx_serial_in`

## Requirements
- R1: `fmt[1:0]` selects the framing: 00 word-start-on-edge (left-justified), 01 word-start-one-bit-after-edge (I2S), 10 word-end-at-edge (right-justified), 11 pulse-synchronized (DSP). `fmt[3:2]` selects the word length: 00 = 16, 01 = 20, 10 or 11 = 24 bits. Serial bits and `lrclk` are sampled on rising `bclk`.
- R2: Left-justified: the MSB is the first bit sampled after `lrclk` changes. `lrclk` high marks the left word and low marks the right word.
- R3: I2S: the MSB is the bit sampled one `bclk` after the `lrclk` change. `lrclk` low marks the left word.
- R4: Right-justified: the LSB is the last bit sampled before `lrclk` changes, and bits earlier than the word in the half-frame are ignored. `lrclk` high marks the left word.
- R5: DSP: `lrclk` is high for one bit period. The left MSB is the next bit, and the right MSB follows the left LSB immediately. Bits after the right LSB are ignored.
- R6: A W-bit word appears in `out_*[23:24-W]` with the lower 24-W bits zero. Bits between the LSB and the next word start are ignored.
- R7: Each completed frame produces exactly one `out_valid` pulse, one core cycle wide, carrying that frame's left and right words. The outputs hold their value between pulses.
- R8: While `rst` is high and after it falls, `out_valid` is 0 and both outputs are 0 until the first frame completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset, sampled in both domains |
| fmt | input | 4 | Framing in [1:0], word length in [3:2] |
| bclk | input | 1 | Serial bit clock, asynchronous to clk |
| lrclk | input | 1 | Word select or frame sync, sampled on bclk |
| sdata | input | 1 | Serial data, MSB first |
| out_left | output | 24 | Left sample, left-aligned two's complement |
| out_right | output | 24 | Right sample, left-aligned two's complement |
| out_valid | output | 1 | One-cycle strobe for a new pair |

## Verification
Every framing is tried with every width code, including the reserved code 11. Each run starts with a directed frame of largest-positive left and most-negative right, which exposes sign or alignment slips at the word ends. A second directed frame of all-ones left and value-one right catches a missing or doubled bit at the LSB. Random words follow, and the data line carries random bits wherever no word is defined. A wrong word start, a wrong channel polarity or capture of stray bits therefore shows up as a data mismatch. Counting strobes per run separates lost or duplicated pairs from data errors.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int CNT_W    = 6;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef enum logic [1:0] {
        FRM_LJ  = 2'd0,
        FRM_I2S = 2'd1,
        FRM_RJ  = 2'd2,
        FRM_DSP = 2'd3
    } frame_mode_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } pcm_pair_t;

    // bit index (counted from the MSB) of the last bit of a word
    function automatic logic [CNT_W-1:0] last_idx(input logic [1:0] wcode);
        case (wcode)
            2'd0:    return 6'd15;
            2'd1:    return 6'd19;
            default: return 6'd23;
        endcase
    endfunction

    // last bit of the right word in the pulse-synchronized layout
    function automatic logic [CNT_W-1:0] dsp_right_idx(input logic [1:0] wcode);
        case (wcode)
            2'd0:    return 6'd31;
            2'd1:    return 6'd39;
            default: return 6'd47;
        endcase
    endfunction

    // move a right-aligned raw word to the top of the sample, clear the rest
    function automatic logic [SAMPLE_W-1:0] left_align(input logic [SAMPLE_W-1:0] raw,
                                                       input logic [1:0] wcode);
        case (wcode)
            2'd0:    return {raw[15:0], 8'd0};
            2'd1:    return {raw[19:0], 4'd0};
            default: return raw;
        endcase
    endfunction

    // bits that must be zero in an aligned sample of the given width
    function automatic logic [SAMPLE_W-1:0] pad_mask(input logic [1:0] wcode);
        case (wcode)
            2'd0:    return 24'h0000FF;
            2'd1:    return 24'h00000F;
            default: return 24'h000000;
        endcase
    endfunction

endpackage

// File: rtl/audrx_shift.sv
module audrx_shift
    import audrx_pkg::*;
(
    input  logic      bclk,
    input  logic      rst,
    input  logic      lrclk,
    input  logic      sdata,
    input  logic [3:0] fmt,
    output pcm_pair_t pair,
    output logic      tgl
);

    frame_mode_e mode;
    logic [1:0]  wcode;
    assign mode  = frame_mode_e'(fmt[1:0]);
    assign wcode = fmt[3:2];

    // sampling pipeline, free running so it follows lrclk through reset
    logic                lr_q;
    logic [SAMPLE_W-1:0] sh_q;
    logic [SAMPLE_W-1:0] sh_nx;

    // framing state
    logic             edge_d_q;
    logic             rise_d_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_cur;
    logic             ch_q;
    logic             ch_cur;
    logic             ch_new;
    logic             edge_now;
    logic             start;
    logic             done;
    logic             done_left;
    logic [SAMPLE_W-1:0] raw;
    logic [SAMPLE_W-1:0] left_q;

    always_comb begin
        sh_nx    = {sh_q[SAMPLE_W-2:0], sdata};
        edge_now = (lrclk != lr_q);
        start    = 1'b0;
        ch_new   = 1'b0;
        case (mode)
            FRM_LJ:  begin start = edge_now; ch_new = lrclk;  end
            FRM_I2S: begin start = edge_d_q; ch_new = ~lrclk; end
            FRM_DSP: begin start = rise_d_q; ch_new = 1'b1;   end
            default: ;
        endcase

        if (start)                cnt_cur = '0;
        else if (cnt_q == CNT_MAX) cnt_cur = cnt_q;
        else                      cnt_cur = cnt_q + 1'b1;

        ch_cur    = start ? ch_new : ch_q;
        done      = 1'b0;
        done_left = 1'b0;
        raw       = sh_nx;
        case (mode)
            FRM_RJ: begin
                // the half-frame just ended; its LSB was the previous bit
                done      = edge_now;
                done_left = lr_q;
                raw       = sh_q;
            end
            FRM_DSP: begin
                if (cnt_cur == last_idx(wcode)) begin
                    done      = 1'b1;
                    done_left = 1'b1;
                end else if (cnt_cur == dsp_right_idx(wcode)) begin
                    done = 1'b1;
                end
            end
            default: begin
                done      = (cnt_cur == last_idx(wcode));
                done_left = ch_cur;
            end
        endcase
    end

    always_ff @(posedge bclk) begin
        lr_q <= lrclk;
        sh_q <= sh_nx;
    end

    always_ff @(posedge bclk) begin
        if (rst) begin
            edge_d_q <= 1'b0;
            rise_d_q <= 1'b0;
            cnt_q    <= CNT_MAX;
            ch_q     <= 1'b0;
            left_q   <= '0;
            pair     <= '0;
            tgl      <= 1'b0;
        end else begin
            edge_d_q <= edge_now;
            rise_d_q <= edge_now & lrclk;
            cnt_q    <= cnt_cur;
            ch_q     <= ch_cur;
            if (done && done_left) begin
                left_q <= left_align(raw, wcode);
            end
            if (done && !done_left) begin
                pair.left  <= left_q;
                pair.right <= left_align(raw, wcode);
                tgl        <= ~tgl;
            end
        end
    end

    // R7: a new pair needs at least two words, so the toggle never flips on adjacent bits
    a_r7_toggle_spacing: assert property (@(posedge bclk) disable iff (rst)
        (tgl != $past(tgl)) |=> (tgl == $past(tgl)));

    // R6: the holding register never carries nonzero padding when handed over
    a_r6_pair_padding: assert property (@(posedge bclk) disable iff (rst)
        (tgl != $past(tgl)) |-> (((pair.left | pair.right) & pad_mask(wcode)) == '0));

endmodule

// File: rtl/audrx_cdc.sv
module audrx_cdc
    import audrx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tgl_async,
    input  pcm_pair_t           pair_async,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right,
    output logic                out_valid
);

    // two synchronizing flops plus one for edge detection
    logic [2:0] sync_q;
    logic       hit;

    assign hit = sync_q[2] ^ sync_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= '0;
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            sync_q    <= {sync_q[1:0], tgl_async};
            out_valid <= hit;
            if (hit) begin
                out_left  <= pair_async.left;
                out_right <= pair_async.right;
            end
        end
    end

    // R7: strobe is a single cycle wide
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R7: samples only change together with the strobe
    a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> ($stable(out_left) && $stable(out_right)));

    // R8: nothing is announced in the cycle after reset
    a_r8_quiet_after_reset: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: rtl/audrx_serial_in.sv
module audrx_serial_in
    import audrx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  fmt,
    input  logic        bclk,
    input  logic        lrclk,
    input  logic        sdata,
    output logic [23:0] out_left,
    output logic [23:0] out_right,
    output logic        out_valid
);

    pcm_pair_t pair;
    logic      tgl;

    audrx_shift u_shift (
        .bclk  (bclk),
        .rst   (rst),
        .lrclk (lrclk),
        .sdata (sdata),
        .fmt   (fmt),
        .pair  (pair),
        .tgl   (tgl)
    );

    audrx_cdc u_cdc (
        .clk        (clk),
        .rst        (rst),
        .tgl_async  (tgl),
        .pair_async (pair),
        .out_left   (out_left),
        .out_right  (out_right),
        .out_valid  (out_valid)
    );

    // R6: presented samples carry zero padding below the selected width
    a_r6_pad_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (((out_left | out_right) & pad_mask(fmt[3:2])) == '0));

endmodule

// File: tb/tb_audrx_serial_in.sv
`timescale 1ns/1ps
module tb_audrx_serial_in;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  fmt = 4'd0;
    logic        bclk = 1'b0;
    logic        lrclk = 1'b0;
    logic        sdata = 1'b0;
    logic [23:0] out_left;
    logic [23:0] out_right;
    logic        out_valid;

    always #5 clk = ~clk;

    audrx_serial_in dut (
        .clk(clk), .rst(rst), .fmt(fmt), .bclk(bclk), .lrclk(lrclk),
        .sdata(sdata), .out_left(out_left), .out_right(out_right), .out_valid(out_valid)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam int NF = 4;
    logic [23:0] log_l [0:15];
    logic [23:0] log_r [0:15];
    int          log_n = 0;
    logic [23:0] exp_l [0:NF-1];
    logic [23:0] exp_r [0:NF-1];

    // monitor, away from the active edge
    always @(negedge clk) begin
        if (rst) log_n = 0;
        else if (out_valid) begin
            if (log_n < 16) begin
                log_l[log_n] = out_left;
                log_r[log_n] = out_right;
            end
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // one bit period; bench changes lines while bclk is low
    task automatic bit_out(input logic l, input logic d);
        bclk = 1'b0; lrclk = l; sdata = d;
        #43;
        bclk = 1'b1;
        #43;
    endtask

    function automatic logic [23:0] place(input logic [23:0] w, input int wl);
        logic [23:0] m;
        m = (24'd1 << wl) - 24'd1;
        return (w & m) << (24 - wl);
    endfunction

    task automatic send_frame(input int mode, input int wl,
                              input logic [23:0] lw, input logic [23:0] rw);
        for (int b = 0; b < 64; b++) begin
            automatic int h = b / 32;
            automatic int j = b % 32;
            automatic logic [23:0] w = (h != 0) ? rw : lw;
            automatic logic l = 1'b0;
            automatic logic d = 1'($urandom % 2);
            case (mode)
                0: begin l = (h == 0); if (j < wl) d = w[wl-1-j]; end
                1: begin l = (h == 1); if (j >= 1 && j <= wl) d = w[wl-j]; end
                2: begin l = (h == 0); if (j >= 32 - wl) d = w[31-j]; end
                default: begin
                    l = (b == 0);
                    if (b >= 1 && b <= wl) d = lw[wl-b];
                    else if (b > wl && b <= 2*wl) d = rw[2*wl-b];
                end
            endcase
            bit_out(l, d);
        end
    endtask

    task automatic do_reset(input logic idle_lr);
        rst = 1'b1;
        for (int i = 0; i < 4; i++) bit_out(idle_lr, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4711));
        for (int m = 0; m < 4; m++) begin
            for (int wc = 0; wc < 4; wc++) begin
                automatic int wl = (wc == 0) ? 16 : (wc == 1) ? 20 : 24;
                automatic logic idle = (m == 1 || m == 2);
                automatic string req = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
                fmt = {2'(wc), 2'(m)};  // R1: width in [3:2], framing in [1:0]
                do_reset(idle);
                // R8: quiet, cleared outputs after reset
                chk(!out_valid && out_left == 0 && out_right == 0, "R8", "reset state",
                    {out_left, out_right}, 48'd0);
                for (int f = 0; f < NF; f++) begin
                    automatic logic [23:0] lw = 24'($urandom);
                    automatic logic [23:0] rw = 24'($urandom);
                    if (f == 0) begin
                        lw = (24'd1 << (wl-1)) - 24'd1;   // largest positive
                        rw = 24'd1 << (wl-1);             // most negative
                    end else if (f == 1) begin
                        lw = 24'hFFFFFF;                  // minus one
                        rw = 24'd1;
                    end
                    exp_l[f] = place(lw, wl);
                    exp_r[f] = place(rw, wl);
                    send_frame(m, wl, lw, rw);
                end
                if (m == 2) bit_out(1'b1, 1'($urandom % 2)); // R4: edge that closes last word
                repeat (20) @(negedge clk);
                // R7: one strobe per frame
                chk(log_n == NF, "R7", "strobe count", 48'(log_n), 48'(NF));
                for (int f = 0; f < NF; f++) begin
                    // R6 alignment checked along with each framing
                    chk(log_l[f] == exp_l[f] && log_r[f] == exp_r[f], req, "sample pair (R6)",
                        {log_l[f], log_r[f]}, {exp_l[f], exp_r[f]});
                end
                // R7: outputs hold the last pair
                chk(out_left == exp_l[NF-1] && out_right == exp_r[NF-1] && !out_valid,
                    "R7", "hold after last pair", {out_left, out_right},
                    {exp_l[NF-1], exp_r[NF-1]});
            end
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule